// File: doc/BRIEF.md
# Decode Stage with Skid Buffer and Early Branch Squash

This block is the decode step of an out-of-order core's front end, placed between instruction fetch and register rename. Each cycle it takes a packed group of up to `W` instruction slots from fetch and hands up to `W` payloads to rename through a registered output. Real opcode decoding happens elsewhere. What this stage owns is flow control and the early correction of PC-relative branches whose mispredict flag is already set.

Three downstream stages can ask it to hold: rename, execute and commit. When any of them does, the stage parks every incoming slot in a skid buffer and pulses a block notice to fetch. When all three release the stage, it empties the buffer, oldest first, before any fresh slot reaches rename. It pulses an unblock notice only when the buffer is drained.

A flush from commit beats everything else and throws away all the work the stage holds. When the stage finds a mispredicted branch itself, it forwards the branch and drops the younger slots. If the branch has a delay slot, the delay-slot instruction is forwarded too. The stage then sends the corrected target to fetch.

Fetch and rename exchange slot groups as valid masks. There is no ready wire, so back-pressure works through the stall inputs and the block notice. Fetch must stop sending within `FETCH_LAT` cycles of a block pulse. Rename must accept every lane that `rn_mask` marks valid. An asserted stall keeps `rn_mask` at zero from the next cycle on.

Top module: `dec_stage`

## Requirements
- R1: After reset, `state_o` is Idle (code 1), `rn_mask`, `redir_valid`, `block_up` and `unblock_up` are 0, and `active` is 0. State codes: Running 0, Idle 1, WaitDelay 2, Squashing 3, Blocked 4, Unblocking 5.
- R2: With no stall, a fetch group (mask packed from lane 0) shows up on `rn_mask`/`rn_data` one cycle later, slot order preserved, mask packed from lane 0. Slot layout is bits [7:0] payload, [15:8] branch target, bit 16 has-delay-slot, bit 17 mispredicted.
- R3: In any state other than Squashing, an asserted rename, execute or commit stall gives `rn_mask` 0 on the next cycle, moves the stage to Blocked, captures that cycle's fetch slots, and raises `block_up` for one cycle on entry. This applies when leaving Unblocking too.
- R4: Once every stall is low, Blocked moves to Unblocking. The buffer then releases up to `W` slots per cycle, oldest first, and fresh fetch slots queue behind it. The stage leaves for Running (or WaitDelay) with a one-cycle `unblock_up` only in the cycle the buffer empties and no fresh slot arrives.
- R5: `commit_squash` wins over stalls and over a self-detected squash. The next cycle shows Squashing with `rn_mask` 0, the buffer empty and no redirect. Input during Squashing is discarded. Squashing then goes to Idle, and nothing that was buffered before the flush ever reaches rename.
- R6: A mispredicted branch without a delay slot is forwarded with every older slot of its group. Younger slots are dropped. `redir_valid` pulses with `redir_pc` equal to the branch target, the state becomes Squashing, and the fetch slots of the following cycle are discarded.
- R7: If a mispredicted branch has a delay slot and that slot is in the same group, the stage forwards everything up to and including the delay slot and redirects in the same cycle.
- R8: If the delay slot has not yet arrived, the stage forwards the branch without a redirect and remembers the target. It waits in WaitDelay, or keeps the pending squash through a Blocked period. The next non-empty group forwards only its first slot, whose own branch flags are ignored, and then redirects to the saved target.
- R9: `active` is low exactly in Idle. Running with an empty fetch group goes to Idle.
- R10: The skid buffer holds `SKID_DEPTH` slots. It never overflows or underflows when fetch obeys the block notice. `SKID_DEPTH` must be a power of two and at least `W*FETCH_LAT`. A full buffer drains in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_mask | input | W | Valid lanes of the fetch group, packed from lane 0 |
| fe_slots | input | W*(DATA_W+PC_W+2) | Fetch slots, lane i at i*SLOT_W |
| stall_rename | input | 1 | Hold request from rename |
| stall_exec | input | 1 | Hold request from execute |
| stall_commit | input | 1 | Hold request from commit |
| commit_squash | input | 1 | Flush from commit |
| rn_mask | output | W | Valid lanes toward rename |
| rn_data | output | W*DATA_W | Payloads toward rename |
| redir_valid | output | 1 | One-cycle redirect to fetch |
| redir_pc | output | PC_W | Corrected fetch target |
| block_up | output | 1 | One-cycle notice that the stage blocked |
| unblock_up | output | 1 | One-cycle notice that the buffer drained |
| active | output | 1 | Stage holds or expects work |
| state_o | output | 3 | Current state code |

## Verification
The bench stalls the stage from each source, including a fresh stall while it is unblocking. It fills the buffer to full capacity and adds fresh input behind queued slots. A design that lost, duplicated or reordered buffered slots, or let fresh slots jump ahead, shows up as a payload mismatch in the scoreboard. A flush from commit is issued over buffered slots and over a same-cycle branch squash, and a later stall/release cycle shows whether stale slots reappear. Branch cases cover a mispredict in lane 0 and in lane 1, a delay slot in the same group, a delay slot in the next group, and a delay slot across a block period. A design that forwarded the dropped younger slots, redirected too early or to the wrong target, or honoured the flags of the delay slot would fail the redirect or the payload checks.

// File: rtl/dec_pkg.sv
package dec_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_WAITDS  = 3'd2,
    ST_SQUASH  = 3'd3,
    ST_BLOCK   = 3'd4,
    ST_UNBLOCK = 3'd5
  } dstate_e;
endpackage

// File: rtl/dec_skid_buf.sv
module dec_skid_buf #(
  parameter int W      = 2,
  parameter int SLOT_W = 18,
  parameter int DEPTH  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic [$clog2(W+1)-1:0]        push_n,
  input  logic [W*SLOT_W-1:0]           push_slots,
  input  logic [$clog2(W+1)-1:0]        pop_n,
  output logic [W*SLOT_W-1:0]           head_slots,
  output logic [W-1:0]                  head_valid,
  output logic [$clog2(DEPTH+1)-1:0]    count
);
  localparam int CW = $clog2(W+1);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH+1);

  if ((DEPTH & (DEPTH - 1)) != 0) begin : g_depth_chk
    $error("skid depth must be a power of two");
  end

  logic [SLOT_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_q, wr_q;
  logic [NW-1:0]     cnt_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      if (CW'(i) < push_n) mem[wr_q + AW'(i)] <= push_slots[i*SLOT_W +: SLOT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + AW'(push_n);
      rd_q  <= rd_q + AW'(pop_n);
      cnt_q <= cnt_q + NW'(push_n) - NW'(pop_n);
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      head_slots[i*SLOT_W +: SLOT_W] = mem[rd_q + AW'(i)];
      head_valid[i] = NW'(i) < cnt_q;
    end
  end

  assign count = cnt_q;

  AST_SKID_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (32'(cnt_q) + 32'(push_n) - 32'(pop_n) <= DEPTH)); // R10
  AST_SKID_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (32'(pop_n) <= 32'(cnt_q))); // R10
endmodule

// File: rtl/dec_branch_scan.sv
module dec_branch_scan #(
  parameter int W      = 2,
  parameter int DATA_W = 8,
  parameter int PC_W   = 8
) (
  input  logic [W-1:0]                    grp_valid,
  input  logic [W*(DATA_W+PC_W+2)-1:0]    grp_slots,
  input  logic                            pend_q,
  input  logic [PC_W-1:0]                 pend_pc,
  output logic [$clog2(W+1)-1:0]          fwd_n,
  output logic                            sq_now,
  output logic [PC_W-1:0]                 sq_pc,
  output logic                            pend_set,
  output logic [PC_W-1:0]                 pend_pc_new
);
  localparam int CW     = $clog2(W+1);
  localparam int SLOT_W = DATA_W + PC_W + 2;
  localparam int B_TGT  = DATA_W;
  localparam int B_DLY  = DATA_W + PC_W;
  localparam int B_MIS  = DATA_W + PC_W + 1;

  logic [CW-1:0] n;
  logic          found;

  always_comb begin
    n = '0;
    for (int i = 0; i < W; i++) n = n + CW'(grp_valid[i]);
    fwd_n       = n;
    sq_now      = 1'b0;
    sq_pc       = pend_pc;
    pend_set    = 1'b0;
    pend_pc_new = '0;
    found       = 1'b0;
    if (pend_q && n != '0) begin
      // first slot is the delay slot; its own flags are not looked at
      fwd_n  = CW'(1);
      sq_now = 1'b1;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (!found && grp_valid[i] && grp_slots[i*SLOT_W + B_MIS]) begin
          found = 1'b1;
          if (!grp_slots[i*SLOT_W + B_DLY]) begin
            fwd_n  = CW'(i + 1);
            sq_now = 1'b1;
            sq_pc  = grp_slots[i*SLOT_W + B_TGT +: PC_W];
          end else if (CW'(i + 1) < n) begin
            fwd_n  = CW'(i + 2);
            sq_now = 1'b1;
            sq_pc  = grp_slots[i*SLOT_W + B_TGT +: PC_W];
          end else begin
            fwd_n       = CW'(i + 1);
            pend_set    = 1'b1;
            pend_pc_new = grp_slots[i*SLOT_W + B_TGT +: PC_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/dec_stage.sv
module dec_stage
  import dec_pkg::*;
#(
  parameter int W          = 2,
  parameter int DATA_W     = 8,
  parameter int PC_W       = 8,
  parameter int SKID_DEPTH = 8,
  parameter int FETCH_LAT  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [W-1:0]                 fe_mask,
  input  logic [W*(DATA_W+PC_W+2)-1:0] fe_slots,
  input  logic                         stall_rename,
  input  logic                         stall_exec,
  input  logic                         stall_commit,
  input  logic                         commit_squash,
  output logic [W-1:0]                 rn_mask,
  output logic [W*DATA_W-1:0]          rn_data,
  output logic                         redir_valid,
  output logic [PC_W-1:0]              redir_pc,
  output logic                         block_up,
  output logic                         unblock_up,
  output logic                         active,
  output logic [2:0]                   state_o
);
  localparam int SLOT_W   = DATA_W + PC_W + 2;
  localparam int CW       = $clog2(W+1);
  localparam int NW       = $clog2(SKID_DEPTH+1);
  localparam int MIN_SKID = W * FETCH_LAT;

  if (SKID_DEPTH < MIN_SKID) begin : g_skid_chk
    $error("skid depth below width times fetch latency");
  end

  dstate_e          state_q, state_d;
  logic             pend_q, pend_d;
  logic [PC_W-1:0]  pend_pc_q, pend_pc_d;
  logic [W-1:0]     rn_mask_d;
  logic [W*DATA_W-1:0] rn_data_d;
  logic             block_d, unblock_d;

  logic             stall_any, from_skid, process, own_sq, flush;
  logic [CW-1:0]    in_n, push_n, pop_n, fwd_n;
  logic [W-1:0]     grp_valid, head_valid;
  logic [W*SLOT_W-1:0] grp_slots, head_slots;
  logic [NW-1:0]    skid_cnt;
  logic             sq_now, pend_set;
  logic [PC_W-1:0]  sq_pc, pend_pc_new;

  assign stall_any = stall_rename | stall_exec | stall_commit;
  assign in_n      = CW'($countones(fe_mask));
  assign from_skid = (state_q == ST_UNBLOCK);
  assign grp_valid = from_skid ? head_valid : fe_mask;
  assign grp_slots = from_skid ? head_slots : fe_slots;
  assign process   = !commit_squash && !stall_any &&
                     (state_q inside {ST_RUN, ST_IDLE, ST_WAITDS, ST_UNBLOCK});
  assign own_sq    = process && sq_now;
  assign flush     = commit_squash || own_sq;

  dec_branch_scan #(.W(W), .DATA_W(DATA_W), .PC_W(PC_W)) u_scan (
    .grp_valid   (grp_valid),
    .grp_slots   (grp_slots),
    .pend_q      (pend_q),
    .pend_pc     (pend_pc_q),
    .fwd_n       (fwd_n),
    .sq_now      (sq_now),
    .sq_pc       (sq_pc),
    .pend_set    (pend_set),
    .pend_pc_new (pend_pc_new)
  );

  dec_skid_buf #(.W(W), .SLOT_W(SLOT_W), .DEPTH(SKID_DEPTH)) u_skid (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .push_n     (push_n),
    .push_slots (fe_slots),
    .pop_n      (pop_n),
    .head_slots (head_slots),
    .head_valid (head_valid),
    .count      (skid_cnt)
  );

  // buffer traffic
  always_comb begin
    push_n = '0;
    if (!flush) begin
      unique case (state_q)
        ST_RUN, ST_IDLE, ST_WAITDS: push_n = stall_any ? in_n : '0;
        ST_BLOCK, ST_UNBLOCK:       push_n = in_n;
        default:                    push_n = '0;
      endcase
    end
    pop_n = (process && from_skid && !own_sq) ? fwd_n : '0;
  end

  // pending delay-slot squash
  always_comb begin
    pend_d    = pend_q;
    pend_pc_d = pend_pc_q;
    if (flush) begin
      pend_d = 1'b0;
    end else if (process && pend_set) begin
      pend_d    = 1'b1;
      pend_pc_d = pend_pc_new;
    end
  end

  // status machine
  always_comb begin
    state_d   = state_q;
    block_d   = 1'b0;
    unblock_d = 1'b0;
    if (commit_squash) begin
      state_d = ST_SQUASH;
    end else begin
      unique case (state_q)
        ST_RUN, ST_IDLE, ST_WAITDS: begin
          if (stall_any) begin
            state_d = ST_BLOCK;
            block_d = 1'b1;
          end else if (own_sq)   state_d = ST_SQUASH;
          else if (in_n == '0)   state_d = pend_q ? ST_WAITDS : ST_IDLE;
          else                   state_d = pend_d ? ST_WAITDS : ST_RUN;
        end
        ST_BLOCK: state_d = stall_any ? ST_BLOCK : ST_UNBLOCK;
        ST_UNBLOCK: begin
          if (stall_any) begin
            state_d = ST_BLOCK;
            block_d = 1'b1;
          end else if (own_sq) begin
            state_d = ST_SQUASH;
          end else if (skid_cnt == NW'(fwd_n) && in_n == '0) begin
            state_d   = pend_d ? ST_WAITDS : ST_RUN;
            unblock_d = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // lanes toward rename
  always_comb begin
    for (int i = 0; i < W; i++) begin
      rn_mask_d[i] = process && (CW'(i) < fwd_n);
      rn_data_d[i*DATA_W +: DATA_W] = rn_mask_d[i] ? grp_slots[i*SLOT_W +: DATA_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_q      <= 1'b0;
      pend_pc_q   <= '0;
      rn_mask     <= '0;
      rn_data     <= '0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      block_up    <= 1'b0;
      unblock_up  <= 1'b0;
    end else begin
      state_q     <= state_d;
      pend_q      <= pend_d;
      pend_pc_q   <= pend_pc_d;
      rn_mask     <= rn_mask_d;
      rn_data     <= rn_data_d;
      redir_valid <= own_sq;
      redir_pc    <= own_sq ? sq_pc : redir_pc;
      block_up    <= block_d;
      unblock_up  <= unblock_d;
    end
  end

  assign active  = (state_q != ST_IDLE);
  assign state_o = state_q;

  AST_STALL_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_any && !commit_squash && state_q != ST_SQUASH) |=> (rn_mask == '0)); // R3
  AST_BLOCK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    block_up |-> (state_q == ST_BLOCK)); // R3
  AST_UNBLOCK_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    unblock_up |-> (skid_cnt == '0 && (state_q == ST_RUN || state_q == ST_WAITDS))); // R4
  AST_COMMIT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    commit_squash |=> (state_q == ST_SQUASH && skid_cnt == '0 && rn_mask == '0 && !redir_valid)); // R5
  AST_REDIR_SQUASHING: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (state_q == ST_SQUASH && skid_cnt == '0 && !pend_q)); // R6
  AST_RN_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((rn_mask & (rn_mask + 1'b1)) == '0)); // R2
endmodule

// File: tb/dec_stage_test.sv
module dec_stage_test;
  localparam int CLK_P  = 10;
  localparam int W      = 2;
  localparam int SLOT_W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] fe_mask = '0;
  logic [W*SLOT_W-1:0] fe_slots = '0;
  logic stall_rename = 1'b0, stall_exec = 1'b0, stall_commit = 1'b0, commit_squash = 1'b0;
  logic [W-1:0] rn_mask;
  logic [W*8-1:0] rn_data;
  logic redir_valid, block_up, unblock_up, active;
  logic [7:0] redir_pc;
  logic [2:0] state_o;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  dec_stage uut (
    .clk(clk), .rst_n(rst_n), .fe_mask(fe_mask), .fe_slots(fe_slots),
    .stall_rename(stall_rename), .stall_exec(stall_exec), .stall_commit(stall_commit),
    .commit_squash(commit_squash), .rn_mask(rn_mask), .rn_data(rn_data),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .block_up(block_up),
    .unblock_up(unblock_up), .active(active), .state_o(state_o)
  );

  function automatic logic [17:0] sl(input logic [7:0] pay, input logic [7:0] pc = 8'h00,
                                     input logic dly = 1'b0, input logic mis = 1'b0);
    return {mis, dly, pc, pay};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: pops expected payloads lane by lane (R2 order, R4 drain order)
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      for (int i = 0; i < W; i++) begin
        if (rn_mask[i]) begin
          if (exp_q.size() == 0) chk(1'b0, "R2 unexpected payload", int'(rn_data[i*8 +: 8]), 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rn_data[i*8 +: 8] == e, "R2/R4 payload order", int'(rn_data[i*8 +: 8]), int'(e));
          end
        end
      end
    end
  end

  // driver: apply one cycle of stimulus; stall bits {commit,exec,rename}
  task automatic step(input logic [1:0] m, input logic [17:0] s0, input logic [17:0] s1,
                      input logic [2:0] st = 3'b000, input logic cs = 1'b0);
    fe_mask = m;
    fe_slots = {s1, s0};
    {stall_commit, stall_exec, stall_rename} = st;
    commit_squash = cs;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input logic [1:0] m, input logic [2:0] st,
                            input logic rv = 1'b0, input logic [7:0] pc = 8'h00,
                            input logic blk = 1'b0, input logic unb = 1'b0);
    chk(rn_mask == m, {req, " rn_mask"}, int'(rn_mask), int'(m));
    chk(state_o == st, {req, " state"}, int'(state_o), int'(st));
    chk(redir_valid == rv, {req, " redir_valid"}, int'(redir_valid), int'(rv));
    if (rv) chk(redir_pc == pc, {req, " redir_pc"}, int'(redir_pc), int'(pc));
    chk(block_up == blk, {req, " block_up"}, int'(block_up), int'(blk));
    chk(unblock_up == unb, {req, " unblock_up"}, int'(unblock_up), int'(unb));
  endtask

  initial begin
    #(CLK_P*20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 reset", 2'b00, 3'd1);
    chk(active == 1'b0, "R1 active", int'(active), 0);
    rst_n = 1'b1;

    // R2 pass-through
    exp_q.push_back(8'h10); exp_q.push_back(8'h11);
    step(2'b11, sl(8'h10), sl(8'h11));
    expect_out("R2 full group", 2'b11, 3'd0);
    chk(active == 1'b1, "R9 active running", int'(active), 1);
    exp_q.push_back(8'h12);
    step(2'b01, sl(8'h12), '0);
    expect_out("R2 single lane", 2'b01, 3'd0);
    step(2'b00, '0, '0);
    expect_out("R9 idle", 2'b00, 3'd1);
    chk(active == 1'b0, "R9 active idle", int'(active), 0);

    // R3 rename stall, R4 drain with fresh input behind
    exp_q.push_back(8'h20); exp_q.push_back(8'h21);
    step(2'b11, sl(8'h20), sl(8'h21), 3'b001);
    expect_out("R3 rename stall", 2'b00, 3'd4, 1'b0, 8'h00, 1'b1);
    exp_q.push_back(8'h22);
    step(2'b01, sl(8'h22), '0, 3'b001);
    expect_out("R3 held", 2'b00, 3'd4);
    exp_q.push_back(8'h23); exp_q.push_back(8'h24);
    step(2'b11, sl(8'h23), sl(8'h24));
    expect_out("R4 to unblocking", 2'b00, 3'd5);
    exp_q.push_back(8'h25);
    step(2'b01, sl(8'h25), '0);
    expect_out("R4 drain 1", 2'b11, 3'd5);
    step(2'b00, '0, '0);
    expect_out("R4 drain 2", 2'b11, 3'd5);
    step(2'b00, '0, '0);
    expect_out("R4 drained", 2'b11, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1);
    step(2'b00, '0, '0);
    expect_out("R9 back to idle", 2'b00, 3'd1);

    // R3 execute and commit stalls, re-block while unblocking
    exp_q.push_back(8'h30);
    step(2'b01, sl(8'h30), '0, 3'b010);
    expect_out("R3 exec stall", 2'b00, 3'd4, 1'b0, 8'h00, 1'b1);
    step(2'b00, '0, '0);
    expect_out("R4 unblocking", 2'b00, 3'd5);
    step(2'b00, '0, '0, 3'b100);
    expect_out("R3 commit stall reblock", 2'b00, 3'd4, 1'b0, 8'h00, 1'b1);
    step(2'b00, '0, '0);
    expect_out("R4 unblocking again", 2'b00, 3'd5);
    step(2'b00, '0, '0);
    expect_out("R4 single drain", 2'b01, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1);

    // R5 commit flush over buffered slots
    step(2'b11, sl(8'h40), sl(8'h41), 3'b001);
    expect_out("R5 pre-flush block", 2'b00, 3'd4, 1'b0, 8'h00, 1'b1);
    step(2'b01, sl(8'h42), '0, 3'b001, 1'b1);
    expect_out("R5 flush", 2'b00, 3'd3);
    step(2'b11, sl(8'h43), sl(8'h44));
    expect_out("R5 squashing discards", 2'b00, 3'd1);
    exp_q.push_back(8'h45);
    step(2'b01, sl(8'h45), '0);
    expect_out("R5 resume", 2'b01, 3'd0);
    step(2'b00, '0, '0, 3'b001);
    expect_out("R5 empty block", 2'b00, 3'd4, 1'b0, 8'h00, 1'b1);
    step(2'b00, '0, '0);
    expect_out("R5 empty unblock", 2'b00, 3'd5);
    step(2'b00, '0, '0);
    expect_out("R5 nothing stale", 2'b00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1);

    // R6 mispredict in lane 0, no delay slot
    exp_q.push_back(8'h50);
    step(2'b11, sl(8'h50, 8'h40, 1'b0, 1'b1), sl(8'h51));
    expect_out("R6 lane0 squash", 2'b01, 3'd3, 1'b1, 8'h40);
    step(2'b11, sl(8'h52), sl(8'h53));
    expect_out("R6 next discarded", 2'b00, 3'd1);

    // R6 mispredict in lane 1
    exp_q.push_back(8'h54); exp_q.push_back(8'h55);
    step(2'b11, sl(8'h54), sl(8'h55, 8'h22, 1'b0, 1'b1));
    expect_out("R6 lane1 squash", 2'b11, 3'd3, 1'b1, 8'h22);
    step(2'b00, '0, '0);
    expect_out("R6 settle", 2'b00, 3'd1);

    // R7 delay slot in the same group
    exp_q.push_back(8'h60); exp_q.push_back(8'h61);
    step(2'b11, sl(8'h60, 8'h50, 1'b1, 1'b1), sl(8'h61));
    expect_out("R7 same-group delay", 2'b11, 3'd3, 1'b1, 8'h50);
    step(2'b00, '0, '0);
    expect_out("R7 settle", 2'b00, 3'd1);

    // R8 delay slot in the next group
    exp_q.push_back(8'h70); exp_q.push_back(8'h71);
    step(2'b11, sl(8'h70), sl(8'h71, 8'h60, 1'b1, 1'b1));
    expect_out("R8 wait delay", 2'b11, 3'd2);
    step(2'b00, '0, '0);
    expect_out("R8 still waiting", 2'b00, 3'd2);
    exp_q.push_back(8'h72);
    step(2'b11, sl(8'h72, 8'h77, 1'b0, 1'b1), sl(8'h73));
    expect_out("R8 delayed redirect", 2'b01, 3'd3, 1'b1, 8'h60);
    step(2'b00, '0, '0);
    expect_out("R8 settle", 2'b00, 3'd1);

    // R8 pending squash across a block period
    exp_q.push_back(8'h80); exp_q.push_back(8'h81);
    step(2'b11, sl(8'h80), sl(8'h81, 8'h68, 1'b1, 1'b1));
    expect_out("R8 pend", 2'b11, 3'd2);
    step(2'b11, sl(8'h82), sl(8'h83), 3'b010);
    expect_out("R8 pend blocked", 2'b00, 3'd4, 1'b0, 8'h00, 1'b1);
    step(2'b00, '0, '0);
    expect_out("R8 pend unblocking", 2'b00, 3'd5);
    exp_q.push_back(8'h82);
    step(2'b00, '0, '0);
    expect_out("R8 redirect from buffer", 2'b01, 3'd3, 1'b1, 8'h68);
    step(2'b00, '0, '0);
    expect_out("R8 settle2", 2'b00, 3'd1);

    // R5 commit flush beats own squash
    step(2'b11, sl(8'h90, 8'h30, 1'b0, 1'b1), sl(8'h91), 3'b000, 1'b1);
    expect_out("R5 priority", 2'b00, 3'd3);
    step(2'b00, '0, '0);
    expect_out("R5 settle", 2'b00, 3'd1);

    // R10 fill buffer to capacity and drain in order
    for (int g = 0; g < 4; g++) begin
      exp_q.push_back(8'hA0 + 8'(2*g)); exp_q.push_back(8'hA1 + 8'(2*g));
      step(2'b11, sl(8'hA0 + 8'(2*g)), sl(8'hA1 + 8'(2*g)), 3'b001);
      expect_out("R10 fill", 2'b00, 3'd4, 1'b0, 8'h00, (g == 0));
    end
    step(2'b00, '0, '0);
    expect_out("R10 release", 2'b00, 3'd5);
    for (int g = 0; g < 4; g++) begin
      step(2'b00, '0, '0);
      expect_out("R10 drain", 2'b11, (g == 3) ? 3'd0 : 3'd5, 1'b0, 8'h00, 1'b0, (g == 3));
    end

    step(2'b00, '0, '0);
    step(2'b00, '0, '0);
    chk(exp_q.size() == 0, "R2 all expected delivered", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule